// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Software Fill

This block is a small fully associative cache of address translations. Each entry maps a virtual page to a physical frame and belongs to one process. A lookup presents a 32-bit virtual address together with the current process identifier. One clock later the block reports one of three outcomes:

- a hit, with the physical address;
- a miss trap, telling software to compute the translation, load it and retry the access;
- a protection trap, for a store to a page that is marked read-only.

Each entry has its own page size: 4 KB, 2 MB or 1 GB. The size sets how many upper address bits take part in the comparison and how many low bits pass straight through from the virtual address. Software writes entries at an index it chooses. It can remove stale mappings in two ways: an invalidate request clears every entry that matches a given page and process, and a flush clears the whole cache in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After synchronous reset every entry is invalid, all response outputs are 0, and the first lookup reports a miss.
- R2: A lookup that matches a 4 KB entry sets `rsp_valid` and `rsp_hit` one cycle after `lk_valid`, with `rsp_pa` = {frame[31:12], va[11:0]}.
- R3: A lookup that matches no entry sets `miss_trap`, clears `rsp_hit` and drives `rsp_pa` to 0. `miss_trap` and `rsp_hit` are never both 1.
- R4: An entry matches only if its stored process ID equals `cur_pid`. Two entries with the same page and different process IDs each translate only for their own process.
- R5: For a 2 MB entry (size code 1), only va[31:21] is compared, and `rsp_pa` = {frame[31:21], va[20:0]}.
- R6: For a 1 GB entry (size code 2), only va[31:30] is compared, and `rsp_pa` = {frame[31:30], va[29:0]}. Size codes 0 and 3 both mean 4 KB.
- R7: A store lookup (`lk_write`=1) that hits an entry with its writable bit clear sets `prot_trap` and `rsp_hit`, and does not set `miss_trap`. A load to the same entry, or a store to a writable entry, leaves `prot_trap` at 0.
- R8: When several entries match, the entry with the lowest index supplies the translation.
- R9: `inv_en` clears every valid entry whose process ID equals `inv_pid` and whose page, compared at that entry's own size, covers `inv_vpn`. Entries of other processes are unaffected.
- R10: `flush_en` clears every entry within one cycle. Flush takes priority over a fill in the same cycle.
- R11: `wr_en` loads the entry at `wr_idx` and makes it valid, replacing any earlier contents of that index. For that index, a fill takes priority over an invalidate in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pid | input | 8 | Process identifier of the running process |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a store |
| wr_en | input | 1 | Software fill strobe |
| wr_idx | input | 3 | Entry index to fill |
| wr_vpn | input | 20 | Virtual page bits va[31:12] of the new entry |
| wr_pfn | input | 20 | Physical frame bits pa[31:12] of the new entry |
| wr_pid | input | 8 | Process ID of the new entry |
| wr_size | input | 2 | Page size code: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| wr_writable | input | 1 | Stores allowed to the new entry |
| inv_en | input | 1 | Invalidate by page and process |
| inv_vpn | input | 20 | Virtual page bits va[31:12] to invalidate |
| inv_pid | input | 8 | Process ID to invalidate |
| flush_en | input | 1 | Clear all entries |
| rsp_valid | output | 1 | Response present, one cycle after a lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 32 | Physical address, 0 on a miss |
| miss_trap | output | 1 | No matching entry |
| prot_trap | output | 1 | Store to a read-only entry |

## Verification
The hardest situation to reach is one where several entries match the same address at once. Entries of different sizes can overlap, and duplicates can be loaded deliberately. In that case the lowest index must win, and an invalidate must remove all of the matching entries together.

To build this case, the stimulus loads a 4 KB entry that lies inside a lower-indexed 1 GB entry, and a higher-indexed duplicate of an existing 4 KB page. It then looks up the overlapping addresses. It also invalidates a page that two entries share, and checks that a different process's entry for the same page still hits.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int unsigned VA_W   = 32;
    localparam int unsigned OFF_W  = 12;
    localparam int unsigned PN_W   = VA_W - OFF_W;
    localparam int unsigned PID_W  = 8;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef struct packed {
        logic [PN_W-1:0]  vtag;
        logic [PN_W-1:0]  ptag;
        logic [PID_W-1:0] pid;
        pg_size_e         size;
        logic             wrt;
    } tlb_entry_t;

    // number of low address bits that pass through untranslated
    function automatic int unsigned page_shift(pg_size_e s);
        case (s)
            PG_2M:   return 21;
            PG_1G:   return 30;
            default: return 12;
        endcase
    endfunction

    // page-number bits that take part in the compare
    function automatic logic [PN_W-1:0] pn_mask(pg_size_e s);
        logic [PN_W-1:0] low;
        low = (PN_W'(1) << (page_shift(s) - OFF_W)) - PN_W'(1);
        return ~low;
    endfunction

    function automatic logic pn_covers(logic [PN_W-1:0] tag, logic [PN_W-1:0] pn,
                                       pg_size_e s);
        return ((tag ^ pn) & pn_mask(s)) == '0;
    endfunction

    function automatic logic [VA_W-1:0] make_pa(logic [PN_W-1:0] frame,
                                                logic [VA_W-1:0] va, pg_size_e s);
        logic [VA_W-1:0] low;
        low = (VA_W'(1) << page_shift(s)) - VA_W'(1);
        return ({frame, {OFF_W{1'b0}}} & ~low) | (va & low);
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  tlb_entry_t             wr_entry,
    input  logic                   inv_en,
    input  logic [PN_W-1:0]        inv_vpn,
    input  logic [PID_W-1:0]       inv_pid,
    input  logic                   flush_en,
    input  logic [PN_W-1:0]        lk_vpn,
    input  logic [PID_W-1:0]       lk_pid,
    output logic [DEPTH-1:0]       lk_match,
    output tlb_entry_t             entries [DEPTH]
);

    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] inv_hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic       v_q;
        tlb_entry_t e_q;
        logic       sel_w;

        assign sel_w = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                e_q <= '0;
            end else if (flush_en) begin
                v_q <= 1'b0;
            end else if (sel_w) begin
                v_q <= 1'b1;
                e_q <= wr_entry;
            end else if (inv_hit[g]) begin
                v_q <= 1'b0;
            end
        end

        assign inv_hit[g]  = inv_en && v_q && (e_q.pid == inv_pid)
                             && pn_covers(e_q.vtag, inv_vpn, e_q.size);
        assign lk_match[g] = v_q && (e_q.pid == lk_pid)
                             && pn_covers(e_q.vtag, lk_vpn, e_q.size);
        assign valid_q[g]  = v_q;
        assign entries[g]  = e_q;
    end

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_en |=> (valid_q == '0));

    // R11
    fill_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush_en) |=> valid_q[$past(wr_idx)]);

    // R9
    inv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_en && !flush_en && !wr_en) |=> ((valid_q & $past(inv_hit)) == '0));

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [DEPTH-1:0] gnt;

    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |match;

    // R8
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt & ~match) == '0) && (any == (gnt != '0)));

    // R8
    gnt_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        ((match & (gnt - 1'b1) & ~gnt) == '0));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         cur_pid,
    input  logic               lk_valid,
    input  logic [31:0]        lk_va,
    input  logic               lk_write,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [19:0]        wr_vpn,
    input  logic [19:0]        wr_pfn,
    input  logic [7:0]         wr_pid,
    input  logic [1:0]         wr_size,
    input  logic               wr_writable,
    input  logic               inv_en,
    input  logic [19:0]        inv_vpn,
    input  logic [7:0]         inv_pid,
    input  logic               flush_en,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [31:0]        rsp_pa,
    output logic               miss_trap,
    output logic               prot_trap
);

    tlb_entry_t           new_ent;
    tlb_entry_t           entries [ENTRIES];
    logic [ENTRIES-1:0]   match;
    logic                 any;
    logic [IDX_W-1:0]     win;
    tlb_entry_t           win_ent;

    always_comb begin
        new_ent.vtag = wr_vpn;
        new_ent.ptag = wr_pfn;
        new_ent.pid  = wr_pid;
        new_ent.size = pg_size_e'(wr_size);
        new_ent.wrt  = wr_writable;
    end

    tlb_entry_array #(.DEPTH(ENTRIES), .IDX_W(IDX_W)) i_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (new_ent),
        .inv_en   (inv_en),
        .inv_vpn  (inv_vpn),
        .inv_pid  (inv_pid),
        .flush_en (flush_en),
        .lk_vpn   (lk_va[VA_W-1:OFF_W]),
        .lk_pid   (cur_pid),
        .lk_match (match),
        .entries  (entries)
    );

    tlb_first_hit #(.DEPTH(ENTRIES), .IDX_W(IDX_W)) i_pick (
        .clk   (clk),
        .rst   (rst),
        .match (match),
        .any   (any),
        .idx   (win)
    );

    assign win_ent = entries[win];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pa    <= '0;
            miss_trap <= 1'b0;
            prot_trap <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && any;
            miss_trap <= lk_valid && !any;
            prot_trap <= lk_valid && any && lk_write && !win_ent.wrt;
            rsp_pa    <= (lk_valid && any) ? make_pa(win_ent.ptag, lk_va, win_ent.size) : '0;
        end
    end

    // R3
    miss_hit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(miss_trap && rsp_hit));

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (rsp_valid && (rsp_hit != miss_trap)));

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !miss_trap && !prot_trap));

    // R7
    prot_store_chk: assert property (@(posedge clk) disable iff (rst)
        prot_trap |-> (rsp_hit && $past(lk_write)));

endmodule

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  cur_pid;
    logic        lk_valid, lk_write;
    logic [31:0] lk_va;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [19:0] wr_vpn, wr_pfn;
    logic [7:0]  wr_pid;
    logic [1:0]  wr_size;
    logic        wr_writable;
    logic        inv_en;
    logic [19:0] inv_vpn;
    logic [7:0]  inv_pid;
    logic        flush_en;
    logic        rsp_valid, rsp_hit, miss_trap, prot_trap;
    logic [31:0] rsp_pa;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    tlb_xlate i_tlb_xlate (.*);

    // flg = {hit, miss, prot}
    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  pid;
        logic        wr;
        logic [2:0]  flg;
        logic [31:0] pa;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{32'h0040_1ABC, 8'd1, 1'b0, 3'b100, 32'h1234_5ABC, 4'd2},  // R2
        '{32'h0040_1ABC, 8'd2, 1'b0, 3'b100, 32'h0AAA_AABC, 4'd4},  // R4
        '{32'h0040_1ABC, 8'd3, 1'b0, 3'b010, 32'h0000_0000, 4'd4},  // R4
        '{32'h0041_2000, 8'd1, 1'b0, 3'b010, 32'h0000_0000, 4'd3},  // R3
        '{32'h0071_2345, 8'd1, 1'b0, 3'b100, 32'h8031_2345, 4'd5},  // R5
        '{32'h0071_2345, 8'd1, 1'b1, 3'b101, 32'h8031_2345, 4'd7},  // R7
        '{32'h0080_0000, 8'd1, 1'b0, 3'b010, 32'h0000_0000, 4'd5},  // R5
        '{32'h7ABC_DEF0, 8'd2, 1'b0, 3'b100, 32'hFABC_DEF0, 4'd6},  // R6
        '{32'h8000_0000, 8'd2, 1'b0, 3'b010, 32'h0000_0000, 4'd6},  // R6
        '{32'h0040_1FFF, 8'd1, 1'b1, 3'b100, 32'h1234_5FFF, 4'd7}   // R7
    };

    task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic fill(logic [2:0] idx, logic [19:0] vpn, logic [19:0] pfn,
                        logic [7:0] pid, logic [1:0] sz, logic wrt);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_pfn = pfn;
        wr_pid = pid; wr_size = sz; wr_writable = wrt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // response is registered at the posedge between the two negedges
    task automatic lookup(logic [31:0] va, logic [7:0] pid, logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; cur_pid = pid; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    function automatic logic [63:0] resp();
        return {28'd0, rsp_valid, rsp_hit, miss_trap, prot_trap, rsp_pa};
    endfunction

    function automatic logic [63:0] expect_r(logic [2:0] flg, logic [31:0] pa);
        return {28'd0, 1'b1, flg, pa};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cur_pid = '0; lk_valid = 0; lk_va = '0; lk_write = 0;
        wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_pfn = '0; wr_pid = '0;
        wr_size = '0; wr_writable = 0; inv_en = 0; inv_vpn = '0; inv_pid = '0;
        flush_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and first lookup misses
        check("R1", resp(), 64'd0);
        lookup(32'h0040_1ABC, 8'd1, 1'b0);
        check("R1", resp(), expect_r(3'b010, 32'd0));

        fill(3'd0, 20'h00401, 20'h12345, 8'd1, 2'd0, 1'b1);
        fill(3'd1, 20'h00600, 20'h80200, 8'd1, 2'd1, 1'b0);
        fill(3'd2, 20'h40000, 20'hC0000, 8'd2, 2'd2, 1'b1);
        fill(3'd3, 20'h00401, 20'h0AAAA, 8'd2, 2'd0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            lookup(VT[i].va, VT[i].pid, VT[i].wr);
            check($sformatf("R%0d vec%0d", VT[i].rq, i), resp(),
                  expect_r(VT[i].flg, VT[i].pa));
        end

        // R8: 4 KB entry at index 5 lies inside the 1 GB entry at index 2
        fill(3'd5, 20'h70000, 20'h00001, 8'd2, 2'd0, 1'b1);
        lookup(32'h7000_0010, 8'd2, 1'b0);
        check("R8 overlap", resp(), expect_r(3'b100, 32'hF000_0010));
        // R8: duplicate of entry 0 at index 7
        fill(3'd7, 20'h00401, 20'h55555, 8'd1, 2'd0, 1'b1);
        lookup(32'h0040_1004, 8'd1, 1'b0);
        check("R8 dup", resp(), expect_r(3'b100, 32'h1234_5004));

        // R9: invalidate page 0x00401 of pid 1 clears both entries 0 and 7
        @(negedge clk);
        inv_en = 1'b1; inv_vpn = 20'h00401; inv_pid = 8'd1;
        @(negedge clk);
        inv_en = 1'b0;
        lookup(32'h0040_1004, 8'd1, 1'b0);
        check("R9 cleared", resp(), expect_r(3'b010, 32'd0));
        lookup(32'h0040_1004, 8'd2, 1'b0);
        check("R9 other pid", resp(), expect_r(3'b100, 32'h0AAA_A004));

        // R11: overwrite index 3
        fill(3'd3, 20'h00401, 20'h0BBBB, 8'd2, 2'd0, 1'b1);
        lookup(32'h0040_1ABC, 8'd2, 1'b0);
        check("R11 replace", resp(), expect_r(3'b100, 32'h0BBB_BABC));

        // R11: fill and invalidate of the same entry together, fill wins
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd4; wr_vpn = 20'h01234; wr_pfn = 20'h00777;
        wr_pid = 8'd4; wr_size = 2'd0; wr_writable = 1'b1;
        inv_en = 1'b1; inv_vpn = 20'h01234; inv_pid = 8'd4;
        @(negedge clk);
        wr_en = 1'b0; inv_en = 1'b0;
        lookup(32'h0123_4008, 8'd4, 1'b0);
        check("R11 fill over inv", resp(), expect_r(3'b100, 32'h0077_7008));

        // R10: flush together with a fill, everything gone
        @(negedge clk);
        flush_en = 1'b1;
        wr_en = 1'b1; wr_idx = 3'd6; wr_vpn = 20'h02000; wr_pfn = 20'h00100;
        wr_pid = 8'd1; wr_size = 2'd0; wr_writable = 1'b1;
        @(negedge clk);
        flush_en = 1'b0; wr_en = 1'b0;
        lookup(32'h7ABC_DEF0, 8'd2, 1'b0);
        check("R10 1G gone", resp(), expect_r(3'b010, 32'd0));
        lookup(32'h0071_2345, 8'd1, 1'b0);
        check("R10 2M gone", resp(), expect_r(3'b010, 32'd0));
        lookup(32'h0200_0000, 8'd1, 1'b0);
        check("R10 fill dropped", resp(), expect_r(3'b010, 32'd0));

        // R2: idle cycle carries no response
        @(negedge clk);
        check("R2 idle", resp(), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule